// File: doc/BRIEF.md
# Host Command Frame Parser

This block sits behind a UART receiver that carries host commands over a wireless serial link (230400 baud on the link side; the block itself sees only whole received bytes with a valid strobe). It decodes a byte-valued control protocol in which every frame opens with a header code in the range 250..253 and is closed by the byte 255. Everything between the header and the terminator is a parameter byte.

For each completed frame the parser pulses a done strobe and reports the frame type. It keeps the parameter bytes of the current frame in a small buffer that can be read by index. It runs an acquisition-enable state from the frame stream. A start frame turns acquisition on and latches its leading parameter bytes as sampling settings. A stop frame turns it off. Patient-information frames are stored and flagged as finished without any interpretation. A frame whose body grows beyond the buffer is abandoned with an error pulse.

Top module: `cmd_frame_parser`

## Requirements
- R1: After a synchronous active-low reset, acq_enable, cmd_done, frame_error, patient_done, settings and param_len are all zero.
- R2: While no frame is open, any received byte outside 250..253 (including 254 and 255) is discarded: no cmd_done, no frame_error, and acq_enable is unchanged.
- R3: When a 255 is received inside an open frame, cmd_done is high for exactly the next cycle. In that cycle cmd_type gives the header minus 250 (0 patient info, 1 patient end, 2 start, 3 stop) and param_len gives the number of body bytes.
- R4: One cycle after cmd_done for a start frame, acq_enable is 1 and settings holds the first SET_BYTES body bytes. Body byte i sits at bits [8i+7:8i]. Byte positions with no body byte read as zero.
- R5: One cycle after cmd_done for a stop frame, acq_enable is 0 and settings keeps its previous value.
- R6: Every body byte other than 255, including the values 250..254, is stored. After a frame completes and until the next header, rd_byte returns body byte rd_idx, or zero when rd_idx is not below param_len's maximum (MAX_PARAMS).
- R7: A frame may carry up to MAX_PARAMS body bytes. Receiving one more non-terminator byte raises frame_error for one cycle without cmd_done and returns the parser to idle, so a later 255 is discarded. acq_enable and settings are unaffected.
- R8: One cycle after cmd_done for a patient-end frame (type 1), patient_done is 1. It returns to 0 one cycle after a 250 header is received. Patient frames do not change acq_enable or settings.
- R9: A byte presented while rx_valid is low is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| rd_idx | input | $clog2(MAX_PARAMS+1) | Parameter buffer read index |
| rd_byte | output | 8 | Parameter byte at rd_idx |
| cmd_done | output | 1 | One-cycle pulse on a completed frame |
| cmd_type | output | 2 | Frame type code, valid with cmd_done |
| param_len | output | $clog2(MAX_PARAMS+1) | Body byte count of the current/last frame |
| frame_error | output | 1 | One-cycle pulse when a frame body overflows |
| acq_enable | output | 1 | Acquisition run state |
| settings | output | 8*SET_BYTES | Leading start-frame parameter bytes |
| patient_done | output | 1 | Patient information marked finished |

## Verification
The bench builds the parser with MAX_PARAMS = 6 and SET_BYTES = 3. This brings the overflow boundary within a few bytes, so the test covers a body of exactly six bytes and an abort on the seventh. With only three settings bytes, both cases can be shown: a start frame longer than the settings field, where the extra bytes do not reach settings, and a shorter one, where the missing positions are zero-filled.

// File: rtl/cfp_pkg.sv
// Shared types and protocol constants for the command frame parser.
package cfp_pkg;
    typedef enum logic [1:0] {
        FT_PATIENT = 2'd0,
        FT_PAT_END = 2'd1,
        FT_START   = 2'd2,
        FT_STOP    = 2'd3
    } ftype_e;

    localparam logic [7:0] HDR_LO = 8'd250;
    localparam logic [7:0] HDR_HI = 8'd253;
    localparam logic [7:0] TERM   = 8'd255;
endpackage

// File: rtl/cfp_frame_fsm.sv
// Frame sequencer: waits for a header code, counts body bytes and issues
// done / error pulses. Assumes one byte per rx_valid cycle and MAX_PARAMS >= 2.
module cfp_frame_fsm
    import cfp_pkg::*;
#(
    parameter int MAX_PARAMS = 32,
    parameter int LEN_W      = $clog2(MAX_PARAMS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             wr_en,
    output logic [LEN_W-1:0] wr_idx,
    output logic             frame_done,
    output logic             frame_err,
    output ftype_e           frame_type,
    output logic [LEN_W-1:0] frame_len,
    output logic             pat_hdr
);
    typedef enum logic {S_IDLE, S_BODY} state_e;

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_PARAMS);

    state_e           state;
    logic [LEN_W-1:0] cnt;
    ftype_e           ftype;
    logic             done_p;
    logic             err_p;
    logic [7:0]       hdr_off;
    logic             is_hdr;

    // Header detection and its type offset
    always_comb begin
        hdr_off = in_byte - HDR_LO;
        is_hdr  = (in_byte >= HDR_LO) && (in_byte <= HDR_HI);
    end

    // Body byte write strobe toward the parameter store
    always_comb begin
        wr_en  = in_valid && (state == S_BODY) && (in_byte != TERM) && (cnt != LEN_MAX);
        wr_idx = cnt;
    end

    // Sequencer state, byte count and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            ftype  <= FT_PATIENT;
            done_p <= 1'b0;
            err_p  <= 1'b0;
        end else begin
            done_p <= 1'b0;
            err_p  <= 1'b0;
            if (in_valid) begin
                case (state)
                    S_IDLE: begin
                        if (is_hdr) begin
                            state <= S_BODY;
                            cnt   <= '0;
                            ftype <= ftype_e'(hdr_off[1:0]);
                        end
                    end
                    default: begin
                        if (in_byte == TERM) begin
                            done_p <= 1'b1;
                            state  <= S_IDLE;
                        end else if (cnt == LEN_MAX) begin
                            err_p <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign frame_done = done_p;
    assign frame_err  = err_p;
    assign frame_type = ftype;
    assign frame_len  = cnt;
    assign pat_hdr    = in_valid && (state == S_IDLE) && (in_byte == HDR_LO);

    // Body count never passes the buffer size
    assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LEN_MAX);

    // A frame ends either completed or aborted, never both
    assert_done_xor_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_p && err_p));

    // Done is a single-cycle pulse
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> !done_p);

    // An idle parser consumes nothing that is not a header
    assert_idle_discard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && in_valid && !is_hdr) |=> (state == S_IDLE && !done_p && !err_p));

    // Nothing moves without a valid byte
    assert_hold_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && state == S_BODY) |=> ($stable(cnt) && state == S_BODY));
endmodule

// File: rtl/cfp_param_store.sv
// Parameter byte buffer: one register per body position, written by the
// sequencer, read by index and exposing the leading bytes for settings.
module cfp_param_store #(
    parameter int MAX_PARAMS = 32,
    parameter int SET_BYTES  = 4,
    parameter int LEN_W      = $clog2(MAX_PARAMS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [LEN_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [LEN_W-1:0]       rd_idx,
    output logic [7:0]             rd_byte,
    output logic [8*SET_BYTES-1:0] head
);
    logic [7:0] mem [MAX_PARAMS];

    // Per-position storage registers
    for (genvar g = 0; g < MAX_PARAMS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= 8'd0;
            else if (wr_en && (wr_idx == LEN_W'(g)))
                mem[g] <= wr_data;
        end
    end

    // Leading bytes for the settings register
    for (genvar h = 0; h < SET_BYTES; h++) begin : g_head
        assign head[8*h +: 8] = mem[h];
    end

    // Indexed read, zero outside the buffer
    always_comb begin
        rd_byte = 8'd0;
        for (int i = 0; i < MAX_PARAMS; i++)
            if (rd_idx == LEN_W'(i))
                rd_byte = mem[i];
    end
endmodule

// File: rtl/cfp_run_ctrl.sv
// Run control: applies completed frames to the acquisition-enable state,
// the settings register and the patient-finished flag. Acts one cycle
// after the done pulse.
module cfp_run_ctrl
    import cfp_pkg::*;
#(
    parameter int SET_BYTES = 4,
    parameter int LEN_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_done,
    input  ftype_e                 frame_type,
    input  logic [LEN_W-1:0]       frame_len,
    input  logic [8*SET_BYTES-1:0] head,
    input  logic                   pat_hdr,
    output logic                   acq_enable,
    output logic [8*SET_BYTES-1:0] settings,
    output logic                   patient_done
);
    // Acquisition state and settings latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_enable <= 1'b0;
            settings   <= '0;
        end else if (frame_done) begin
            if (frame_type == FT_START) begin
                acq_enable <= 1'b1;
                for (int i = 0; i < SET_BYTES; i++)
                    settings[8*i +: 8] <= (LEN_W'(i) < frame_len) ? head[8*i +: 8] : 8'd0;
            end else if (frame_type == FT_STOP) begin
                acq_enable <= 1'b0;
            end
        end
    end

    // Patient-information finished flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            patient_done <= 1'b0;
        else if (frame_done && frame_type == FT_PAT_END)
            patient_done <= 1'b1;
        else if (pat_hdr)
            patient_done <= 1'b0;
    end

    // Acquisition only starts on a completed start frame
    assert_acq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_enable) |-> $past(frame_done && frame_type == FT_START));

    // Acquisition only stops on a completed stop frame
    assert_acq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acq_enable) |-> $past(frame_done && frame_type == FT_STOP));

    // Settings change only through a start frame
    assert_settings_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(settings) |-> $past(frame_done && frame_type == FT_START));

    // Patient flag rises only on a patient-end frame
    assert_patient_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(patient_done) |-> $past(frame_done && frame_type == FT_PAT_END));
endmodule

// File: rtl/cmd_frame_parser.sv
// Host command frame parser top: byte stream in, frame reports,
// parameter buffer read port and acquisition run state out.
// Assumes bytes arrive at most one per cycle from a UART receiver.
module cmd_frame_parser
    import cfp_pkg::*;
#(
    parameter int MAX_PARAMS = 32,
    parameter int SET_BYTES  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rx_valid,
    input  logic [7:0]                        rx_byte,
    input  logic [$clog2(MAX_PARAMS+1)-1:0]   rd_idx,
    output logic [7:0]                        rd_byte,
    output logic                              cmd_done,
    output logic [1:0]                        cmd_type,
    output logic [$clog2(MAX_PARAMS+1)-1:0]   param_len,
    output logic                              frame_error,
    output logic                              acq_enable,
    output logic [8*SET_BYTES-1:0]            settings,
    output logic                              patient_done
);
    localparam int LEN_W = $clog2(MAX_PARAMS + 1);

    logic             wr_en;
    logic [LEN_W-1:0] wr_idx;
    logic             f_done;
    logic             f_err;
    ftype_e           f_type;
    logic [LEN_W-1:0] f_len;
    logic             pat_hdr;
    logic [8*SET_BYTES-1:0] head;

    cfp_frame_fsm #(.MAX_PARAMS(MAX_PARAMS), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_byte(rx_byte),
        .wr_en(wr_en), .wr_idx(wr_idx), .frame_done(f_done), .frame_err(f_err),
        .frame_type(f_type), .frame_len(f_len), .pat_hdr(pat_hdr)
    );

    cfp_param_store #(.MAX_PARAMS(MAX_PARAMS), .SET_BYTES(SET_BYTES), .LEN_W(LEN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(rx_byte),
        .rd_idx(rd_idx), .rd_byte(rd_byte), .head(head)
    );

    cfp_run_ctrl #(.SET_BYTES(SET_BYTES), .LEN_W(LEN_W)) u_run (
        .clk(clk), .rst_n(rst_n), .frame_done(f_done), .frame_type(f_type),
        .frame_len(f_len), .head(head), .pat_hdr(pat_hdr),
        .acq_enable(acq_enable), .settings(settings), .patient_done(patient_done)
    );

    assign cmd_done    = f_done;
    assign cmd_type    = f_type;
    assign param_len   = f_len;
    assign frame_error = f_err;

    // Completion and error pulses never coincide at the ports
    assert_port_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && frame_error));
endmodule

// File: tb/sim_cmd_frame_parser.sv
`timescale 1ns/1ps
module sim_cmd_frame_parser;
    localparam int MAXP = 6;
    localparam int SETB = 3;
    localparam int LW   = $clog2(MAXP + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_valid = 1'b0;
    logic [7:0]      rx_byte = 8'd0;
    logic [LW-1:0]   rd_idx = '0;
    logic [7:0]      rd_byte;
    logic            cmd_done;
    logic [1:0]      cmd_type;
    logic [LW-1:0]   param_len;
    logic            frame_error;
    logic            acq_enable;
    logic [8*SETB-1:0] settings;
    logic            patient_done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cmd_frame_parser #(.MAX_PARAMS(MAXP), .SET_BYTES(SETB)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_idx(rd_idx), .rd_byte(rd_byte), .cmd_done(cmd_done), .cmd_type(cmd_type),
        .param_len(param_len), .frame_error(frame_error), .acq_enable(acq_enable),
        .settings(settings), .patient_done(patient_done)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one byte for one cycle; returns at the negedge after capture
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "acq_enable", 32'(acq_enable), 0);
        check("R1", "cmd_done", 32'(cmd_done), 0);
        check("R1", "frame_error", 32'(frame_error), 0);
        check("R1", "patient_done", 32'(patient_done), 0);
        check("R1", "settings", 32'(settings), 0);
        check("R1", "param_len", 32'(param_len), 0);
    endtask

    task automatic t_idle_junk();
        logic [7:0] junk [5] = '{8'd0, 8'd100, 8'd254, 8'd255, 8'd17};
        for (int i = 0; i < 5; i++) begin
            send(junk[i]);
            check("R2", "done on junk", 32'(cmd_done), 0);
            check("R2", "error on junk", 32'(frame_error), 0);
        end
        tick();
        check("R2", "acq after junk", 32'(acq_enable), 0);
    endtask

    task automatic t_start_long();
        send(8'd252); send(8'h11); send(8'h22); send(8'h33); send(8'h44); send(8'd255);
        check("R3", "done", 32'(cmd_done), 1);
        check("R3", "type start", 32'(cmd_type), 2);
        check("R3", "len", 32'(param_len), 4);
        tick();
        check("R3", "done single pulse", 32'(cmd_done), 0);
        check("R4", "acq set", 32'(acq_enable), 1);
        check("R4", "settings", 32'(settings), 32'h332211);
        rd_idx = 3; #1;
        check("R6", "rd byte 3", 32'(rd_byte), 32'h44);
        rd_idx = 0; #1;
        check("R6", "rd byte 0", 32'(rd_byte), 32'h11);
    endtask

    task automatic t_start_short();
        send(8'd252); send(8'hAB); send(8'd255);
        check("R3", "len short", 32'(param_len), 1);
        tick();
        check("R4", "zero-filled settings", 32'(settings), 32'h0000AB);
        check("R4", "acq still on", 32'(acq_enable), 1);
    endtask

    task automatic t_stop();
        send(8'd253); send(8'h05); send(8'd255);
        check("R3", "done stop", 32'(cmd_done), 1);
        check("R3", "type stop", 32'(cmd_type), 3);
        tick();
        check("R5", "acq cleared", 32'(acq_enable), 0);
        check("R5", "settings kept", 32'(settings), 32'h0000AB);
    endtask

    task automatic t_patient();
        send(8'd250); send(8'h41); send(8'd252); send(8'd254); send(8'd250); send(8'd255);
        check("R3", "type patient", 32'(cmd_type), 0);
        check("R6", "len with header-valued data", 32'(param_len), 4);
        rd_idx = 1; #1;
        check("R6", "data 252 stored", 32'(rd_byte), 252);
        rd_idx = 2; #1;
        check("R6", "data 254 stored", 32'(rd_byte), 254);
        rd_idx = 3'd7; #1;
        check("R6", "out of range read", 32'(rd_byte), 0);
        send(8'd251); send(8'd255);
        check("R3", "type patient end", 32'(cmd_type), 1);
        check("R3", "len zero", 32'(param_len), 0);
        tick();
        check("R8", "patient_done set", 32'(patient_done), 1);
        check("R8", "acq untouched", 32'(acq_enable), 0);
        check("R8", "settings untouched", 32'(settings), 32'h0000AB);
        send(8'd250);
        tick();
        check("R8", "patient_done cleared", 32'(patient_done), 0);
        send(8'd255);
        tick();
    endtask

    task automatic t_overflow();
        send(8'd252);
        for (int i = 0; i < MAXP; i++) send(8'(8'h60 + i));
        send(8'd255);
        check("R7", "full body done", 32'(cmd_done), 1);
        check("R7", "full body len", 32'(param_len), MAXP);
        check("R7", "full body no error", 32'(frame_error), 0);
        tick();
        check("R4", "settings from full body", 32'(settings), 32'h626160);
        send(8'd253); send(8'd255); tick();
        check("R5", "stopped before overflow", 32'(acq_enable), 0);
        send(8'd252);
        for (int i = 0; i < MAXP; i++) begin
            send(8'h01);
            check("R7", "no early error", 32'(frame_error), 0);
        end
        send(8'h01);
        check("R7", "error pulse", 32'(frame_error), 1);
        check("R7", "no done on abort", 32'(cmd_done), 0);
        tick();
        check("R7", "error single pulse", 32'(frame_error), 0);
        send(8'd255);
        check("R7", "stray terminator ignored", 32'(cmd_done), 0);
        tick();
        check("R7", "acq unchanged", 32'(acq_enable), 0);
        check("R7", "settings unchanged", 32'(settings), 32'h626160);
    endtask

    task automatic t_valid_low();
        @(negedge clk);
        rx_byte = 8'd252;
        repeat (3) @(negedge clk);
        rx_byte = 8'd255;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        check("R9", "header without valid ignored", 32'(cmd_done), 0);
        send(8'd253); send(8'h09);
        @(negedge clk);
        rx_byte = 8'h77;
        repeat (3) @(negedge clk);
        check("R9", "len unchanged while invalid", 32'(param_len), 1);
        send(8'd255);
        check("R9", "frame still completes", 32'(cmd_done), 1);
        check("R9", "len after resume", 32'(param_len), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_idle_junk();
        t_start_long();
        t_start_short();
        t_stop();
        t_patient();
        t_overflow();
        t_valid_low();
        repeat (2) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule